// File: doc/BRIEF.md
# I2C Target with Clock Stretching

This block is a target (slave) node on a two-wire I2C bus. It watches the clock and data lines through synchronizers and detects START and STOP conditions. It shifts in an address byte and answers only when the 7-bit address matches its `dev_addr` input. Bytes written by the bus controller go to local logic through a valid/taken handshake. Bytes read by the controller come from local logic through a request/valid handshake.

The block drives each bus line only low, through a drive-low enable, so it fits an open-drain pad. When local logic has not yet consumed a written byte or supplied a read byte, the block holds SCL low. The controller then waits. A repeated START returns the block to address reception at any point. A controller that does not acknowledge a read byte ends the read.

Top module: `i2c_target_stretch`

## Requirements
- R1: A START (SDA falling while SCL is high) begins address reception from any state. A STOP (SDA rising while SCL is high) releases both lines and clears `tx_req`. After reset, both drive enables, `rx_valid` and `tx_req` are 0.
- R2: Bits are sampled on rising SCL, MSB first. The first seven bits form the address and the eighth bit is the direction (1 = read). On a match with `dev_addr`, SDA is pulled low for the whole ninth clock.
- R3: On an address mismatch, the block never drives SDA or SCL and never raises `rx_valid` until the next START.
- R4: On a write, each received byte appears on `rx_data` with `rx_valid` = 1 after its eighth bit and is acknowledged in the ninth clock. `rx_valid` stays set until `rx_taken` is pulsed.
- R5: After the acknowledge clock of a written byte, SCL is held low while that byte remains unconsumed. SCL is released within a few cycles of the `rx_taken` pulse.
- R6: On a read, the block raises `tx_req` and holds SCL low until a `tx_valid` pulse loads `tx_data`. That byte is then driven on SDA MSB first, with each bit changed only while SCL is low.
- R7: On a read, a master acknowledge (SDA low in the ninth clock) makes the block request the next byte. A master non-acknowledge makes it release SDA and SCL and request nothing more.
- R8: A repeated START in the middle of a write restarts address reception without a STOP, so a following read address is acknowledged and served.
- R9: The SDA drive enable changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_addr | input | 7 | Own 7-bit bus address |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_drive_low | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_drive_low | output | 1 | 1 pulls SDA low (acknowledge or data 0) |
| rx_data | output | 8 | Last byte written by the controller |
| rx_valid | output | 1 | `rx_data` holds an unconsumed byte |
| rx_taken | input | 1 | One-cycle pulse: local logic consumed `rx_data` |
| tx_data | input | 8 | Byte to send on the next read |
| tx_valid | input | 1 | One-cycle pulse: `tx_data` is ready |
| tx_req | output | 1 | The block waits for a read byte |

## Verification
The assertions check the following on every cycle:
- SDA drive changes only after SCL has been sampled low.
- SCL is held only in the two waiting states.
- `tx_req` never appears without a stretch.
- An unconsumed written byte stays valid.
- A STOP releases everything.

Only the bench's scenarios can show the protocol-level behaviour:
- that the address comparison gives the right answer for matching and non-matching addresses;
- that read bytes leave in MSB-first order with the right values;
- that a master non-acknowledge ends the read;
- that a repeated START leads into a served read.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BITS,
    ST_WR_ACK,
    ST_WR_HOLD,
    ST_RD_LOAD,
    ST_RD_BITS,
    ST_RD_ACK
  } tgt_state_t;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_s,
  output logic line_q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '1;
      line_q <= 1'b1;
    end else begin
      chain  <= {chain[STAGES-2:0], line_i};
      line_q <= chain[STAGES-1];
    end
  end

  assign line_s = chain[STAGES-1];
endmodule

// File: rtl/i2ct_cond.sv
module i2ct_cond (
  input  logic scl_s,
  input  logic scl_q,
  input  logic sda_s,
  input  logic sda_q,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise,
  output logic scl_fall
);
  // SDA edges only count while SCL is stable high.
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
endmodule

// File: rtl/i2ct_fsm.sv
module i2ct_fsm
  import i2ct_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] dev_addr,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  output logic          scl_drive_low,
  output logic          sda_drive_low,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  input  logic          rx_taken,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_req
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW);

  tgt_state_t    state;
  logic [DW-1:0] shreg;
  logic [CW-1:0] bitcnt;
  logic          rd_mode;
  logic          m_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      shreg         <= '0;
      bitcnt        <= '0;
      rd_mode       <= 1'b0;
      m_ack         <= 1'b0;
      scl_drive_low <= 1'b0;
      sda_drive_low <= 1'b0;
      rx_data       <= '0;
      rx_valid      <= 1'b0;
      tx_req        <= 1'b0;
    end else begin
      if (rx_taken) rx_valid <= 1'b0;
      if (stop_det) begin
        state         <= ST_IDLE;
        sda_drive_low <= 1'b0;
        scl_drive_low <= 1'b0;
        tx_req        <= 1'b0;
      end else if (start_det) begin
        state         <= ST_ADDR;
        bitcnt        <= '0;
        sda_drive_low <= 1'b0;
        scl_drive_low <= 1'b0;
        tx_req        <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg  <= {shreg[DW-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == LAST) begin
              if (shreg[AW:1] == dev_addr) begin
                sda_drive_low <= 1'b1;
                rd_mode       <= shreg[0];
                state         <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              sda_drive_low <= 1'b0;
              bitcnt        <= '0;
              if (rd_mode) begin
                scl_drive_low <= 1'b1;
                tx_req        <= 1'b1;
                state         <= ST_RD_LOAD;
              end else begin
                state <= ST_WR_BITS;
              end
            end
          end
          ST_WR_BITS: begin
            if (scl_rise) begin
              shreg  <= {shreg[DW-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == LAST) begin
              rx_data       <= shreg;
              rx_valid      <= 1'b1;
              sda_drive_low <= 1'b1;
              state         <= ST_WR_ACK;
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_drive_low <= 1'b0;
              bitcnt        <= '0;
              if (rx_valid && !rx_taken) begin
                scl_drive_low <= 1'b1;
                state         <= ST_WR_HOLD;
              end else begin
                state <= ST_WR_BITS;
              end
            end
          end
          ST_WR_HOLD: begin
            if (rx_taken || !rx_valid) begin
              scl_drive_low <= 1'b0;
              state         <= ST_WR_BITS;
            end
          end
          ST_RD_LOAD: begin
            if (tx_valid) begin
              shreg         <= tx_data;
              sda_drive_low <= ~tx_data[DW-1];
              scl_drive_low <= 1'b0;
              tx_req        <= 1'b0;
              bitcnt        <= '0;
              state         <= ST_RD_BITS;
            end
          end
          ST_RD_BITS: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt == LAST) begin
                sda_drive_low <= 1'b0;
                state         <= ST_RD_ACK;
              end else begin
                shreg         <= {shreg[DW-2:0], 1'b0};
                sda_drive_low <= ~shreg[DW-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (m_ack) begin
                scl_drive_low <= 1'b1;
                tx_req        <= 1'b1;
                state         <= ST_RD_LOAD;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_drive_low) |-> !$past(scl_s)); // R9
  AST_HOLD_ONLY_WAITING: assert property (@(posedge clk) disable iff (rst)
    scl_drive_low |-> (state == ST_WR_HOLD || state == ST_RD_LOAD)); // R5
  AST_RX_KEPT_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_taken && !(state == ST_WR_BITS && scl_fall && bitcnt == LAST))
      |=> rx_valid); // R4
  AST_REQ_WITH_STRETCH: assert property (@(posedge clk) disable iff (rst)
    tx_req |-> scl_drive_low); // R6
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (!sda_drive_low && !scl_drive_low && !tx_req)); // R1
endmodule

// File: rtl/i2c_target_stretch.sv
module i2c_target_stretch #(
  parameter int AW          = 7,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] dev_addr,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_drive_low,
  output logic          sda_drive_low,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  input  logic          rx_taken,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_req
);
  logic scl_s, scl_q, sda_s, sda_q;
  logic start_det, stop_det, scl_rise, scl_fall;

  i2ct_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst(rst), .line_i(scl_i), .line_s(scl_s), .line_q(scl_q)
  );
  i2ct_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst(rst), .line_i(sda_i), .line_s(sda_s), .line_q(sda_q)
  );

  i2ct_cond u_cond (
    .scl_s(scl_s), .scl_q(scl_q), .sda_s(sda_s), .sda_q(sda_q),
    .start_det(start_det), .stop_det(stop_det),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  i2ct_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst(rst), .dev_addr(dev_addr),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_taken(rx_taken),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_req(tx_req)
  );
endmodule

// File: tb/i2c_target_stretch_tb_top.sv
module i2c_target_stretch_tb_top;
  localparam int HALF = 20;
  localparam logic [6:0] MY_ADDR = 7'h5A;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       m_scl_low = 1'b0;
  logic       m_sda_low = 1'b0;
  logic       rx_taken = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       scl_drive_low, sda_drive_low, rx_valid, tx_req;
  logic [7:0] rx_data;
  logic       scl_line, sda_line;

  int n_chk = 0;
  int n_fail = 0;
  int sda_cycles = 0;
  int scl_cycles = 0;
  int r9_viol = 0;
  logic prev_sda_drv = 1'b0;
  logic prev_scl_line = 1'b1;

  always #2.5 clk = ~clk;

  assign scl_line = ~(m_scl_low | scl_drive_low);
  assign sda_line = ~(m_sda_low | sda_drive_low);

  i2c_target_stretch dut_i (
    .clk(clk), .rst(rst), .dev_addr(MY_ADDR),
    .scl_i(scl_line), .sda_i(sda_line),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_taken(rx_taken),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_req(tx_req)
  );

  // Bus monitor: drive-cycle counters and the SDA-change rule (R9).
  always @(negedge clk) begin
    if (!rst) begin
      if (sda_drive_low) sda_cycles <= sda_cycles + 1;
      if (scl_drive_low) scl_cycles <= scl_cycles + 1;
      if (sda_drive_low !== prev_sda_drv && prev_scl_line) r9_viol <= r9_viol + 1;
    end
    prev_sda_drv  <= sda_drive_low;
    prev_scl_line <= scl_line;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half_wait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_line) @(negedge clk);
  endtask

  task automatic m_start();
    m_sda_low = 1'b0;
    half_wait();
    m_scl_low = 1'b0;
    wait_scl_high();
    half_wait();
    m_sda_low = 1'b1;
    half_wait();
    m_scl_low = 1'b1;
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1;
    half_wait();
    m_scl_low = 1'b0;
    wait_scl_high();
    half_wait();
    m_sda_low = 1'b0;
    half_wait();
  endtask

  task automatic m_bit(input logic b, output logic seen);
    m_sda_low = ~b;
    half_wait();
    m_scl_low = 1'b0;
    wait_scl_high();
    repeat (HALF / 2) @(negedge clk);
    seen = sda_line;
    repeat (HALF / 2) @(negedge clk);
    m_scl_low = 1'b1;
  endtask

  task automatic m_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) m_bit(d[i], s);
    m_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic m_read(input logic give_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      m_bit(1'b1, s);
      d[i] = s;
    end
    m_bit(~give_ack, s);
  endtask

  task automatic pulse_taken();
    @(negedge clk) rx_taken = 1'b1;
    @(negedge clk) rx_taken = 1'b0;
  endtask

  task automatic supply(input logic [7:0] b);
    @(negedge clk);
    tx_data  = b;
    tx_valid = 1'b1;
    @(negedge clk) tx_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset scl_drive_low", scl_drive_low, 0);
    chk("R1 reset sda_drive_low", sda_drive_low, 0);
    chk("R1 reset rx_valid", rx_valid, 0);
    chk("R1 reset tx_req", tx_req, 0);
  endtask

  task automatic t_write();
    logic ack;
    m_start();
    m_byte({MY_ADDR, 1'b0}, ack);
    chk("R2 write address ack", ack, 1);
    m_byte(8'hC3, ack);
    chk("R4 data byte ack", ack, 1);
    repeat (10) @(negedge clk);
    chk("R4 rx_valid", rx_valid, 1);
    chk("R4 rx_data", rx_data, 8'hC3);
    repeat (100) @(negedge clk);
    chk("R5 stretch held", scl_drive_low, 1);
    chk("R5 rx_valid kept", rx_valid, 1);
    pulse_taken();
    repeat (3) @(negedge clk);
    chk("R5 stretch released", scl_drive_low, 0);
    m_byte(8'h5E, ack);
    chk("R4 second byte ack", ack, 1);
    repeat (10) @(negedge clk);
    chk("R4 second rx_data", rx_data, 8'h5E);
    pulse_taken();
    m_stop();
    repeat (10) @(negedge clk);
    chk("R1 after STOP scl", scl_drive_low, 0);
    chk("R1 after STOP sda", sda_drive_low, 0);
  endtask

  task automatic t_mismatch();
    logic ack;
    int sda0, scl0;
    sda0 = sda_cycles;
    scl0 = scl_cycles;
    m_start();
    m_byte({7'h21, 1'b0}, ack);
    chk("R3 foreign address not acked", ack, 0);
    m_byte(8'h00, ack);
    chk("R3 data after foreign address not acked", ack, 0);
    chk("R3 rx_valid stays low", rx_valid, 0);
    chk("R3 SDA never driven", sda_cycles - sda0, 0);
    chk("R3 SCL never held", scl_cycles - scl0, 0);
    m_stop();
  endtask

  task automatic t_read();
    logic ack;
    logic [7:0] d;
    m_start();
    m_byte({MY_ADDR, 1'b1}, ack);
    chk("R2 read address ack", ack, 1);
    repeat (20) @(negedge clk);
    chk("R6 tx_req raised", tx_req, 1);
    chk("R6 stretch while waiting", scl_drive_low, 1);
    supply(8'hA5);
    repeat (4) @(negedge clk);
    chk("R6 tx_req cleared", tx_req, 0);
    m_read(1'b1, d);
    chk("R6 first read byte", d, 8'hA5);
    repeat (20) @(negedge clk);
    chk("R7 ack requests next", tx_req, 1);
    supply(8'h3C);
    m_read(1'b0, d);
    chk("R6 second read byte", d, 8'h3C);
    repeat (40) @(negedge clk);
    chk("R7 nack no request", tx_req, 0);
    chk("R7 nack SCL released", scl_drive_low, 0);
    chk("R7 nack SDA released", sda_drive_low, 0);
    m_stop();
  endtask

  task automatic t_restart();
    logic ack;
    logic [7:0] d;
    m_start();
    m_byte({MY_ADDR, 1'b0}, ack);
    m_byte(8'h77, ack);
    repeat (10) @(negedge clk);
    chk("R4 byte before repeated START", rx_data, 8'h77);
    pulse_taken();
    m_start();
    m_byte({MY_ADDR, 1'b1}, ack);
    chk("R8 address after repeated START acked", ack, 1);
    repeat (20) @(negedge clk);
    chk("R8 read request after repeated START", tx_req, 1);
    supply(8'h81);
    m_read(1'b0, d);
    chk("R8 read byte after repeated START", d, 8'h81);
    m_stop();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    fork
      begin
        t_reset();
        t_write();
        t_mismatch();
        t_read();
        t_restart();
        chk("R9 SDA changes only with SCL low", r9_viol, 0);
      end
      begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule